// File: doc/BRIEF.md
# Serial Host Register Access Port

This block is a four-wire serial slave through which a host processor reads and writes a small bank of 16-bit registers. The host drives an active-low select, a burst serial clock and a serial data line. The block drives a serial data line back, together with an output-enable for the pad's three-state buffer, so that several slaves can share one return line. A mode input hands the pins to a shared test-access function. While that input is high, the port ignores all serial activity.

Each access is one 32-bit frame. The first half is a command word that carries a direction flag and a register address. The second half is the data word. In a write the host sends the data word, and the register changes only once the last data bit has arrived. In a read the block shifts the data word out, changing bits on falling serial-clock edges, so the host captures each bit on the following rising edge. Writable configuration registers appear on a parallel output bus. Read-only status words come in from the surrounding chip. All serial inputs are oversampled by a system clock that runs at least eight times faster than the serial clock.

Top module: `sreg_access_port`

## Requirements
- R1: The command word is sent most significant bit first. Bit 15 is the direction flag (1 = read, 0 = write), bits 5..0 are the register address, and bits 14..6 have no effect on the access.
- R2: In a write, the data word is captured MSB first on rising serial-clock edges. Configuration register a (addresses 0..NCFG-1) appears at cfg_out[16a+15:16a]. It takes the new value only after the 32nd rising edge of the frame and is unchanged before that edge.
- R3: In a read, the data MSB appears on ser_dout after the falling edge that follows the command's last bit. Each later falling edge presents the next bit. The word returned is configuration register a for addresses 0..NCFG-1, status word stat_in[16k+15:16k] for address STAT_BASE+k (default base 32, k from 0 to NSTAT-1), and zero for any other address.
- R4: ser_dout_oe is high only during the data phase of a selected read frame. It is low in write frames, between frames and after the select is released.
- R5: While test_mode is high, no register changes and ser_dout_oe stays low, whatever happens on the serial pins.
- R6: Releasing ser_cs_n before the frame completes abandons the frame: the partial write changes no register, and the next frame is decoded from its first bit.
- R7: Only one data word follows each command. Rising edges after the 32nd in the same selected period change nothing.
- R8: A write to a status address or to an unmapped address changes no register. A read of a status address still returns the status input.
- R9: After reset, every configuration register is zero and ser_dout_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | High hands the pins to the test-access function; the port goes idle |
| ser_clk | input | 1 | Host serial clock |
| ser_cs_n | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ser_dout_oe | output | 1 | Enable for the three-state buffer driving ser_dout |
| stat_in | input | NSTAT*16 | Read-only status words |
| cfg_out | output | NCFG*16 | Configuration register contents |

## Verification
The bench holds back the last data bit of a write and checks that the target register is still unchanged. A design that commits early, or that commits each bit as it arrives, fails that check. Partial frames cut short by the select exercise R6: a design that does not clear its bit counter misreads the following frame and writes the wrong register. Frames carry set reserved bits, status and unmapped targets, a trailing third word, and the test-mode input. A design that decodes reserved bits, accepts a second data word or responds in test mode alters a register or enables the output where the scoreboard and the port checks expect no change.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int CMD_RW_BIT = 15;
  localparam int FRAME_BITS = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // address match against a register index
  function automatic logic addr_hit(input addr_t a, input int idx);
    return a == addr_t'(idx);
  endfunction

  // shift one serial bit into the low end of a word
  function automatic word_t shift_in(input logic [WORD_W-2:0] held, input logic b);
    return {held, b};
  endfunction
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
    end else begin
      stage_q[0] <= raw;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/sap_frame.sv
module sap_frame
  import sap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  sclk_s,
  input  logic  cs_n_s,
  input  logic  din_s,
  input  word_t rd_word,
  output addr_t look_addr,
  output logic  clk_rise,
  output logic  clk_fall,
  output logic  cs_act,
  output logic  wr_commit,
  output addr_t wr_addr,
  output word_t wr_data,
  output logic  dout,
  output logic  dout_oe
);
  localparam int CNT_W    = $clog2(FRAME_BITS + 1);
  localparam int CMD_LAST = WORD_W - 1;
  localparam int DAT_LAST = FRAME_BITS - 1;

  logic              sclk_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] sh_q;
  word_t             nxt_word;
  word_t             tx_q;
  logic              cmd_rw_q;
  addr_t             cmd_addr_q;
  logic              armed_q;
  logic              oe_q;
  logic              frame_ok;

  assign clk_rise  = sclk_s & ~sclk_d;
  assign clk_fall  = ~sclk_s & sclk_d;
  assign cs_act    = ~cs_n_s;
  assign frame_ok  = enable & cs_act;
  assign nxt_word  = shift_in(sh_q, din_s);
  assign look_addr = nxt_word[ADDR_W-1:0];
  assign wr_addr   = cmd_addr_q;
  assign dout      = tx_q[WORD_W-1];
  assign dout_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      cmd_rw_q   <= 1'b0;
      cmd_addr_q <= '0;
      armed_q    <= 1'b0;
      oe_q       <= 1'b0;
      wr_commit  <= 1'b0;
      wr_data    <= '0;
    end else if (!frame_ok) begin
      bit_cnt   <= '0;
      armed_q   <= 1'b0;
      oe_q      <= 1'b0;
      wr_commit <= 1'b0;
    end else begin
      wr_commit <= 1'b0;
      if (clk_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
        sh_q    <= nxt_word[WORD_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(CMD_LAST)) begin
          cmd_rw_q   <= nxt_word[CMD_RW_BIT];
          cmd_addr_q <= nxt_word[ADDR_W-1:0];
          if (nxt_word[CMD_RW_BIT]) begin
            tx_q    <= rd_word;
            armed_q <= 1'b1;
          end
        end
        if (bit_cnt == CNT_W'(DAT_LAST) && !cmd_rw_q) begin
          wr_commit <= 1'b1;
          wr_data   <= nxt_word;
        end
      end
      if (clk_fall && armed_q) begin
        if (!oe_q) oe_q <= 1'b1;
        else       tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sap_regbank.sv
module sap_regbank
  import sap_pkg::*;
#(
  parameter int NCFG      = 8,
  parameter int NSTAT     = 4,
  parameter int STAT_BASE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_commit,
  input  addr_t                   wr_addr,
  input  word_t                   wr_data,
  input  addr_t                   look_addr,
  input  logic [NSTAT*WORD_W-1:0] stat_in,
  output word_t                   rd_word,
  output logic [NCFG*WORD_W-1:0]  cfg_out
);
  word_t cfg_q [NCFG];

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cfg_q[i] <= '0;
      else if (wr_commit && addr_hit(wr_addr, i))  cfg_q[i] <= wr_data;
    end
    assign cfg_out[i*WORD_W +: WORD_W] = cfg_q[i];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCFG; i++)
      if (addr_hit(look_addr, i)) rd_word = cfg_q[i];
    for (int k = 0; k < NSTAT; k++)
      if (addr_hit(look_addr, STAT_BASE + k)) rd_word = stat_in[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/sreg_access_port.sv
module sreg_access_port
  import sap_pkg::*;
#(
  parameter int NCFG      = 8,
  parameter int NSTAT     = 4,
  parameter int STAT_BASE = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    test_mode,
  input  logic                    ser_clk,
  input  logic                    ser_cs_n,
  input  logic                    ser_din,
  output logic                    ser_dout,
  output logic                    ser_dout_oe,
  input  logic [NSTAT*WORD_W-1:0] stat_in,
  output logic [NCFG*WORD_W-1:0]  cfg_out
);
  logic [3:0] pins_s;
  logic       mode_s, sclk_s, cs_n_s, din_s;
  logic       clk_rise, clk_fall, cs_act, wr_commit;
  addr_t      wr_addr, look_addr;
  word_t      wr_data, rd_word;

  sap_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b0010)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .raw({test_mode, ser_clk, ser_cs_n, ser_din}),
    .synced(pins_s)
  );
  assign {mode_s, sclk_s, cs_n_s, din_s} = pins_s;

  sap_frame frame_i (
    .clk(clk), .rst_n(rst_n), .enable(~mode_s),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .din_s(din_s),
    .rd_word(rd_word), .look_addr(look_addr),
    .clk_rise(clk_rise), .clk_fall(clk_fall), .cs_act(cs_act),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(ser_dout), .dout_oe(ser_dout_oe)
  );

  sap_regbank #(.NCFG(NCFG), .NSTAT(NSTAT), .STAT_BASE(STAT_BASE)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .look_addr(look_addr), .stat_in(stat_in),
    .rd_word(rd_word), .cfg_out(cfg_out)
  );
endmodule

// File: rtl/sap_checker.sv
module sap_checker
  import sap_pkg::*;
#(
  parameter int NCFG = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_s,
  input logic                   cs_act,
  input logic                   clk_fall,
  input logic                   wr_commit,
  input addr_t                  wr_addr,
  input logic [NCFG*WORD_W-1:0] cfg_out,
  input logic                   dout_oe
);
  p_oe_idle_in_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |=> !dout_oe);

  p_oe_needs_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !dout_oe);

  p_oe_starts_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(clk_fall));

  p_cfg_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(wr_commit));

  p_cfg_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> (int'($past(wr_addr)) < NCFG));
endmodule

bind sreg_access_port sap_checker #(.NCFG(NCFG)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .cs_act(cs_act),
  .clk_fall(clk_fall), .wr_commit(wr_commit), .wr_addr(wr_addr),
  .cfg_out(cfg_out), .dout_oe(ser_dout_oe)
);

// File: tb/sreg_access_port_tb.sv
module sreg_access_port_tb_top;
  localparam int NCFG = 8;
  localparam int NSTAT = 4;
  localparam int SBASE = 32;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_cs_n = 1'b1;
  logic ser_din = 1'b0;
  logic ser_dout, ser_dout_oe;
  logic [NSTAT*16-1:0] stat_in = {16'h4444, 16'h3333, 16'h2B2B, 16'h1E1E};
  logic [NCFG*16-1:0]  cfg_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [NCFG];
  logic [15:0] exp_q [$];
  logic oe_seen = 1'b0;

  always #4 clk = ~clk;

  sreg_access_port dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
    .stat_in(stat_in), .cfg_out(cfg_out)
  );

  always @(posedge clk) if (ser_dout_oe) oe_seen <= 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(input logic rw, input logic [8:0] rsv, input logic [5:0] a);
    return {rw, rsv, a};
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    if (a < NCFG) return model[a];
    if (a >= SBASE && a < SBASE + NSTAT) return stat_in[(a-SBASE)*16 +: 16];
    return 16'h0;
  endfunction

  task automatic bit_out(input logic b);
    ser_din = b;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send(input logic [47:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk);
    ser_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    ser_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic [8:0] rsv);
    cs_lo();
    send({16'h0, cmd(1'b0, rsv, 6'(a)), d}, 32);
    cs_hi();
    if (a < NCFG && !test_mode) model[a] = d;
  endtask

  task automatic rd(input int a);
    if (!test_mode) exp_q.push_back(exp_read(a));
    cs_lo();
    send({16'h0, cmd(1'b1, 9'h0, 6'(a)), 16'h0}, 32);
    cs_hi();
  endtask

  task automatic chk_cfg(input int a, input logic [15:0] e, input string tag);
    chk(cfg_out[a*16 +: 16] === e, tag, {16'h0, cfg_out[a*16 +: 16]}, {16'h0, e});
  endtask

  // scoreboard monitor: rebuilds read words from ser_dout at rising edges
  int mon_cnt = 0;
  logic mon_rw = 1'b0;
  logic [15:0] mon_word = '0;
  always @(negedge ser_cs_n) mon_cnt = 0;
  initial begin
    forever begin
      @(posedge ser_clk);
      if (!ser_cs_n && !test_mode) begin
        if (mon_cnt == 0) mon_rw = ser_din;
        if (mon_rw && mon_cnt >= 16 && mon_cnt < 32) begin
          chk(ser_dout_oe === 1'b1, "R4 oe during read data", {31'h0, ser_dout_oe}, 32'h1);
          mon_word = {mon_word[14:0], ser_dout};
          if (mon_cnt == 31) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read word", {16'h0, mon_word}, 32'h0);
            else begin
              logic [15:0] e;
              e = exp_q.pop_front();
              chk(mon_word === e, "R3 read word", {16'h0, mon_word}, {16'h0, e});
            end
          end
        end
        mon_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCFG; i++) model[i] = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(ser_dout_oe === 1'b0, "R9 oe after reset", {31'h0, ser_dout_oe}, 32'h0);
    chk(cfg_out === '0, "R9 cfg after reset", cfg_out[31:0], 32'h0);

    // R2 / R3 basic write and read back; R4 no oe in write frame
    oe_seen = 1'b0;
    wr(3, 16'hA5C3, 9'h0);
    chk(oe_seen === 1'b0, "R4 oe quiet in write frame", {31'h0, oe_seen}, 32'h0);
    chk_cfg(3, 16'hA5C3, "R2 write addr 3");
    rd(3);
    chk(ser_dout_oe === 1'b0, "R4 oe off after release", {31'h0, ser_dout_oe}, 32'h0);
    wr(0, 16'h8001, 9'h0);
    rd(0);

    // R2 commit only after the last data bit
    cs_lo();
    send({16'h0, cmd(1'b0, 9'h0, 6'd6), 16'hBEEF} >> 1, 31);
    repeat (4) @(negedge clk);
    chk_cfg(6, 16'h0000, "R2 no commit before bit 32");
    bit_out(1'b1);
    repeat (4) @(negedge clk);
    chk_cfg(6, 16'hBEEF, "R2 commit after bit 32");
    cs_hi();
    model[6] = 16'hBEEF;

    // R1 reserved bits ignored
    wr(1, 16'h1234, 9'h1FF);
    chk_cfg(1, 16'h1234, "R1 reserved bits ignored");
    rd(1);

    // R6 abort partial write, then a full frame decodes cleanly
    cs_lo();
    send({16'h0, cmd(1'b0, 9'h0, 6'd2), 16'h7777} >> 8, 24);
    cs_hi();
    chk_cfg(2, 16'h0000, "R6 aborted write");
    wr(2, 16'h0F0F, 9'h0);
    chk_cfg(2, 16'h0F0F, "R6 frame after abort");

    // R8 status and unmapped writes ignored, status read returns input
    wr(33, 16'hFFFF, 9'h0);
    wr(50, 16'hFFFF, 9'h0);
    chk(cfg_out === {model[7], model[6], model[5], model[4], model[3], model[2], model[1], model[0]},
        "R8 no register change", cfg_out[31:0], {model[1], model[0]});
    rd(33);
    rd(35);
    rd(50);

    // R7 extra word after data is ignored
    cs_lo();
    send({cmd(1'b0, 9'h0, 6'd5), 16'h5A5A, 16'hC3C3}, 48);
    cs_hi();
    model[5] = 16'h5A5A;
    chk_cfg(5, 16'h5A5A, "R7 extra word ignored");
    rd(5);

    // R5 test mode: no write, no output enable
    test_mode = 1'b1;
    repeat (10) @(negedge clk);
    oe_seen = 1'b0;
    wr(4, 16'hDEAD, 9'h0);
    rd(3);
    chk_cfg(4, 16'h0000, "R5 write ignored in test mode");
    chk(oe_seen === 1'b0, "R5 oe quiet in test mode", {31'h0, oe_seen}, 32'h0);
    test_mode = 1'b0;
    repeat (10) @(negedge clk);
    rd(4);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads observed", exp_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule